// File: doc/BRIEF.md
# DMA Channel Status Clear Unit

This block keeps two status flags for each channel of a 32-channel DMA engine. One is the completion (DONE) flag. The other is the interrupt-request flag. The transfer engine raises flags with one-cycle set strobes, one bit per channel. Software lowers them through a small byte-wide register port. The interrupt-request flags leave the block as a vector with one line per channel, wired straight to the interrupt controller. The DONE flags also leave the block, so the descriptor logic can see them.

Software has three ways to clear flags:
- A 32-bit write-1-to-clear bitmap for the interrupt requests. It spans four byte addresses.
- A DONE-clear byte register that takes a channel code.
- An interrupt-clear byte register that takes a channel code in the same way.

The encoded registers let software clear one channel with a single store and no read-modify-write.

The register port is a plain synchronous bus with no handshake and no back-pressure. Every access completes in the cycle it is presented. Read data appears on `bus_rdata` one cycle after `bus_re`, and it reads 0 when no read was requested.

Top module: `dma_status_clear`

## Requirements
- R1: After reset, every DONE flag, every interrupt-request flag and `bus_rdata` are 0.
- R2: A 1 on `done_set[i]` or `irq_set[i]` makes that channel's flag read 1 on the following cycle.
- R3: A write to address n (0 to 3) clears the interrupt request of channel 8n+b for every data bit b that is 1. Data bits that are 0 leave their channels unchanged.
- R4: A read of address n (0 to 3) returns, one cycle later, the interrupt requests of channels 8n+7 down to 8n, as they stood when the read was issued.
- R5: A write to address 4 (DONE clear) with a code (data bits 6:0) from 0 to 31 clears only the DONE flag of that channel. Data bit 7 is ignored.
- R6: A DONE-clear code from 32 to 63 (bit 6 = 0, bit 5 = 1) changes no flag.
- R7: A DONE-clear code from 64 to 127 (bit 6 = 1) clears the DONE flag of every channel.
- R8: A write to address 5 (interrupt clear) decodes its code exactly as R5 to R7 do, but acts on interrupt-request flags.
- R9: Reads of addresses 4 to 7 return 0. Writes to addresses 6 and 7 change no flag.
- R10: When a set strobe and a software clear reach the same flag in the same cycle, the flag ends up set.
- R11: `irq_req` always equals the interrupt-request flags. Clears aimed at one kind of flag never alter the other kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after `bus_re` |
| done_set | input | 32 | Per-channel completion set strobes |
| irq_set | input | 32 | Per-channel interrupt-request set strobes |
| done_flags | output | 32 | Current DONE flags |
| irq_req | output | 32 | Interrupt request lines, one per channel |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold known values once reset is released. They also assume that `bus_re`, `bus_we` and `bus_addr` describe a single access per cycle. The bench meets these assumptions by changing every input only on the falling edge, holding each access for exactly one cycle, and returning the strobes to 0 between operations. This means each assertion's one-cycle window sees a single well-defined access.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int CODE_W        = 7;
  localparam int LANE_W        = 8;
  localparam int DONE_CLR_ADDR = 4;
  localparam int IRQ_CLR_ADDR  = 5;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_ONE  = 2'd1,
    CLR_ALL  = 2'd2
  } clr_kind_e;

  // Bit 6 of the code selects a global clear, bit 5 marks the reserved range.
  function automatic clr_kind_e classify(input logic [1:0] top_bits);
    if (top_bits[1])      return CLR_ALL;
    else if (top_bits[0]) return CLR_NONE;
    else                  return CLR_ONE;
  endfunction
endpackage

// File: rtl/dsc_code_decode.sv
module dsc_code_decode
  import dsc_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic [NUM_CH-1:0] mask
);
  clr_kind_e kind;
  assign kind = classify(code[CODE_W-1:CODE_W-2]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign mask[i] = en && ((kind == CLR_ALL) ||
                            ((kind == CLR_ONE) && (code[4:0] == 5'(i))));
  end
endmodule

// File: rtl/dsc_bus_decode.sv
module dsc_bus_decode
  import dsc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 3
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANE_W-1:0] bus_wdata,
  output logic              done_code_we,
  output logic              irq_code_we,
  output logic [NUM_CH-1:0] map_clr
);
  localparam int LANES = (NUM_CH + LANE_W - 1) / LANE_W;

  assign done_code_we = bus_we && (bus_addr == ADDR_W'(DONE_CLR_ADDR));
  assign irq_code_we  = bus_we && (bus_addr == ADDR_W'(IRQ_CLR_ADDR));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      if (l * LANE_W + b < NUM_CH) begin : g_used
        assign map_clr[l*LANE_W+b] = bus_we && (bus_addr == ADDR_W'(l)) && bus_wdata[b];
      end
    end
  end
endmodule

// File: rtl/dsc_flag_bank.sv
module dsc_flag_bank #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] q
);
  // The set term is applied last, so a completion is never lost to a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/dma_status_clear.sv
module dma_status_clear
  import dsc_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] done_set,
  input  logic [NUM_CH-1:0] irq_set,
  output logic [NUM_CH-1:0] done_flags,
  output logic [NUM_CH-1:0] irq_req
);
  localparam int LANES = (NUM_CH + LANE_W - 1) / LANE_W;

  logic              done_code_we, irq_code_we;
  logic [NUM_CH-1:0] map_clr, done_code_clr, irq_code_clr;
  logic [NUM_CH-1:0] done_q, irq_q;
  logic [LANES*LANE_W-1:0] irq_pad;
  logic [7:0]        rd_next, rd_q;

  dsc_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bus (
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .done_code_we (done_code_we),
    .irq_code_we  (irq_code_we),
    .map_clr      (map_clr)
  );

  dsc_code_decode #(.NUM_CH(NUM_CH)) u_done_code (
    .en   (done_code_we),
    .code (bus_wdata[CODE_W-1:0]),
    .mask (done_code_clr)
  );

  dsc_code_decode #(.NUM_CH(NUM_CH)) u_irq_code (
    .en   (irq_code_we),
    .code (bus_wdata[CODE_W-1:0]),
    .mask (irq_code_clr)
  );

  dsc_flag_bank #(.NUM_CH(NUM_CH)) u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (done_set),
    .clr_i (done_code_clr),
    .q     (done_q)
  );

  dsc_flag_bank #(.NUM_CH(NUM_CH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (irq_set),
    .clr_i (irq_code_clr | map_clr),
    .q     (irq_q)
  );

  // Read path: bitmap lanes return the live request vector, all else reads 0.
  always_comb begin
    irq_pad = '0;
    irq_pad[NUM_CH-1:0] = irq_q;
    rd_next = '0;
    for (int l = 0; l < LANES; l++) begin
      if (bus_re && (bus_addr == ADDR_W'(l))) rd_next = irq_pad[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_next;
  end

  assign bus_rdata  = rd_q;
  assign done_flags = done_q;
  assign irq_req    = irq_q;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [NUM_CH-1:0] done_set,
  input logic [NUM_CH-1:0] irq_set,
  input logic [NUM_CH-1:0] done_flags,
  input logic [NUM_CH-1:0] irq_req
);
  // R2/R10: a set strobe always lands, whatever clear arrives alongside it.
  p_set_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_set | irq_set) != '0) |=>
      (((done_flags & $past(done_set)) == $past(done_set)) &&
       ((irq_req & $past(irq_set)) == $past(irq_set))));

  // R2: flags rise only through a set strobe.
  p_no_spurious_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irq_req & ~$past(irq_req) & ~$past(irq_set)) == '0) &&
              ((done_flags & ~$past(done_flags) & ~$past(done_set)) == '0)));

  // R6: reserved DONE codes clear nothing.
  p_reserved_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4) && bus_wdata[6:5] == 2'b01) |=>
      (done_flags == ($past(done_flags) | $past(done_set))));

  // R7: global DONE clear leaves only fresh sets.
  p_global_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4) && bus_wdata[6]) |=>
      (done_flags == $past(done_set)));

  // R3: a zero bitmap write changes nothing.
  p_zero_map_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr < ADDR_W'(4) && bus_wdata == 8'h00) |=>
      (irq_req == ($past(irq_req) | $past(irq_set))));

  // R9: the clear registers read back zero.
  p_clear_regs_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr >= ADDR_W'(4)) |=> (bus_rdata == 8'h00));

  // R11: interrupt clears never touch DONE flags.
  p_irq_clear_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != ADDR_W'(4)) |=>
      (done_flags == ($past(done_flags) | $past(done_set))));
endmodule

bind dma_status_clear dsc_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .done_set   (done_set),
  .irq_set    (irq_set),
  .done_flags (done_flags),
  .irq_req    (irq_req)
);

// File: tb/tb_dma_status_clear.sv
`timescale 1ns/1ps
module tb_dma_status_clear;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] done_set = '0, irq_set = '0;
  logic [31:0] done_flags, irq_req;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_status_clear dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_set(done_set), .irq_set(irq_set),
    .done_flags(done_flags), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Flags a code clears: 64..127 all, 32..63 none, 0..31 that one channel.
  function automatic logic [31:0] code_mask(input int d);
    int c = d % 128;
    if (c >= 64) return 32'hFFFF_FFFF;
    if (c >= 32) return 32'h0;
    return 32'h1 << c;
  endfunction

  task automatic set_flags(input logic [31:0] dv, input logic [31:0] iv);
    @(negedge clk); done_set = dv; irq_set = iv;
    @(negedge clk); done_set = '0; irq_set = '0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk); bus_re = 1'b1; bus_addr = 3'(a);
    @(negedge clk); bus_re = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", done_flags, 32'h0);
    check("R1 irq", irq_req, 32'h0);
    check("R1 rdata", {24'h0, bus_rdata}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: set strobes land next cycle
    set_flags(32'hA5A5_0F0F, 32'h1234_8001);
    check("R2 done", done_flags, 32'hA5A5_0F0F);
    check("R2 irq", irq_req, 32'h1234_8001);

    // R5 R6 R7: exhaustive DONE-clear codes including bit 7
    for (int d = 0; d < 256; d++) begin
      set_flags('1, '1);
      wr(4, d);
      check("R5/R6/R7 done code", done_flags, ~code_mask(d));
      check("R11 irq untouched by done clear", irq_req, 32'hFFFF_FFFF);
    end

    // R8: exhaustive interrupt-clear codes
    for (int d = 0; d < 256; d++) begin
      set_flags('1, '1);
      wr(5, d);
      check("R8 irq code", irq_req, ~code_mask(d));
      check("R11 done untouched by irq clear", done_flags, 32'hFFFF_FFFF);
    end

    // R3: bitmap write-1-to-clear per lane
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 8; p++) begin
        int pat = (p * 37 + 1) % 256;
        if (p == 0) pat = 0;
        if (p == 7) pat = 255;
        set_flags('1, '1);
        wr(l, pat);
        check("R3 bitmap clear", irq_req, ~(32'(pat) << (8 * l)));
        check("R11 done untouched by bitmap", done_flags, 32'hFFFF_FFFF);
      end
    end

    // R4: bitmap reads return live lanes
    wr(5, 64);
    set_flags('0, 32'hDEAD_BEEF);
    for (int l = 0; l < 4; l++) begin
      rd(l);
      check("R4 read lane", {24'h0, bus_rdata}, (32'hDEAD_BEEF >> (8 * l)) & 32'hFF);
    end

    // R9: clear regs and unused addresses
    for (int a = 4; a < 8; a++) begin
      rd(a);
      check("R9 read zero", {24'h0, bus_rdata}, 32'h0);
    end
    set_flags('1, '1);
    wr(6, 8'hFF);
    wr(7, 8'h40);
    check("R9 unused write irq", irq_req, 32'hFFFF_FFFF);
    check("R9 unused write done", done_flags, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R1 rdata idle zero", {24'h0, bus_rdata}, 32'h0);

    // R10: set wins over a same-cycle clear
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'd3; done_set = 32'h8;
    @(negedge clk); bus_we = 1'b0; done_set = '0;
    check("R10 single clear vs set", done_flags, 32'hFFFF_FFFF);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h7F; done_set = 32'h80;
    @(negedge clk); bus_we = 1'b0; done_set = '0;
    check("R10 global clear vs set", done_flags, 32'h80);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 8'hFF; irq_set = 32'h200;
    @(negedge clk); bus_we = 1'b0; irq_set = '0;
    check("R10 bitmap clear vs set", irq_req, 32'hFFFF_02FF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule